// File: doc/BRIEF.md
# UART Transmit Break and Insertion Sequencer

This block sits in front of the serial line of a UART transmitter. It decides which character goes out next: the next byte of the transmit buffer stream, a single urgent flow-control character (such as XON or XOFF) queued out of band, or a run of break characters. It contains the frame serializer and a bit-period divider, so its output is the serial line itself.

An out-of-band character is held in a one-entry register. It goes out at the next character boundary, ahead of any further buffer byte, and the buffer stream keeps its order and content. A stop command lets the character on the line finish. The block then sends a programmed number of break characters. Each one holds the line low for exactly one full frame of the current format, and the run has no gaps. When the run ends, the line returns high, a one-cycle done pulse is raised and the block stays stopped until a restart command.

Top module: `uart_tx_brk_seq`

## Requirements
- R1: After reset the line is high, no out-of-band character is pending, the block is not stopped, the done pulse is low and the buffer ready output is high.
- R2: A character frame is one start bit (0), then the data bits least significant first, then an optional parity bit, then stop bits (1). Each bit lasts `bit_div_i`+1 clock cycles. The number of data bits is 5 + `data_sel_i` (0 gives 5, 3 gives 8). With `parity_en_i`=1 a parity bit is added, even parity when `parity_odd_i`=0 and odd parity when it is 1. With `two_stop_i`=1 the frame has two stop bits, otherwise one.
- R3: Buffer bytes are accepted on the clock edge where `buf_valid_i` and `buf_ready_o` are both high. They are sent in the order accepted, back to back, with no idle bit time between frames.
- R4: A character loaded with `oos_load_i` is sent at the next character boundary, ahead of the next buffer byte. Buffer bytes already accepted or still waiting are sent unchanged and in order. `oos_pending_o` falls in the cycle the inserted character's start bit begins.
- R5: An inserted character never cuts into a character already on the line, and `buf_ready_o` stays low while one is pending.
- R6: A stop command that arrives during a character lets that character complete. No further buffer byte is taken before the break run.
- R7: A break run of count N holds the line low for exactly N × frame-length × (`bit_div_i`+1) contiguous cycles, where the frame length follows the format of R2.
- R8: A break count of zero sends no break: the line stays high and the block enters the stopped state directly.
- R9: When the break run ends (or at once for a zero count), `brk_done_o` is high for exactly one cycle. In that cycle `stopped_o` is high and the line is high.
- R10: While stopped, no buffer byte is taken and the line stays high. A queued out-of-band character stays pending. `restart_i` resumes normal sending, and the pending character goes out before the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_div_i | input | DIV_W | Bit period in clocks minus one |
| data_sel_i | input | 2 | Data bits minus five |
| parity_en_i | input | 1 | Add a parity bit |
| parity_odd_i | input | 1 | Odd (1) or even (0) parity |
| two_stop_i | input | 1 | Two stop bits when set |
| buf_data_i | input | 8 | Next buffer byte |
| buf_valid_i | input | 1 | Buffer byte available |
| buf_ready_o | output | 1 | Buffer byte accepted this cycle if valid |
| oos_data_i | input | 8 | Out-of-band character |
| oos_load_i | input | 1 | Strobe: queue the out-of-band character |
| oos_pending_o | output | 1 | Out-of-band character waiting |
| stop_cmd_i | input | 1 | Strobe: stop transmission and send break |
| restart_i | input | 1 | Strobe: leave the stopped state |
| brk_count_i | input | BRK_W | Number of break characters |
| txd_o | output | 1 | Serial line, idle high |
| stopped_o | output | 1 | Block is stopped |
| brk_done_o | output | 1 | One-cycle pulse at the end of the break run |

## Verification
The hardest situations to reach are the ones that depend on when an event falls within a character frame. These are an out-of-band load while a buffer byte is mid-frame with more bytes queued, and a stop command that lands mid-frame while another byte waits. The bench forks the strobe a fixed number of clocks after the first frame starts, while a decoder follows the line. It then confirms the decoded order, the exact length of the low run, and that the waiting byte is still unsent while stopped. Break lengths are swept across counts and frame formats and compared against count × length × period computed in the bench.

// File: rtl/uart_seq_pkg.sv
package uart_seq_pkg;

  localparam int FRAME_MAX = 12;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic [1:0] {
    SQ_RUN     = 2'd0,
    SQ_BREAK   = 2'd1,
    SQ_STOPPED = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic [1:0] data_sel;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } frame_cfg_t;

  // Total bit count: start + data + parity + stop
  function automatic logic [LEN_W-1:0] frame_len(frame_cfg_t c);
    return LEN_W'(7 + int'(c.data_sel) + int'(c.par_en) + int'(c.two_stop));
  endfunction

  // Line pattern, bit 0 first on the wire; unused upper bits are stop level
  function automatic logic [FRAME_MAX-1:0] frame_bits(logic [7:0] d, frame_cfg_t c);
    logic [FRAME_MAX-1:0] f;
    logic                 p;
    int                   nd;
    nd   = 5 + int'(c.data_sel);
    f    = '1;
    f[0] = 1'b0;
    p    = c.par_odd;
    for (int i = 0; i < 8; i++) begin
      if (i < nd) begin
        f[1+i] = d[i];
        p      = p ^ d[i];
      end
    end
    if (c.par_en) f[1+nd] = p;
    return f;
  endfunction

endpackage

// File: rtl/uart_bit_clock.sv
module uart_bit_clock #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             cnt_en;

  assign tick   = en && (cnt_q == '0);
  assign cnt_en = restart || en;

  always_comb begin
    cnt_d = cnt_q;
    if (restart || tick) cnt_d = div;
    else if (en)         cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uart_frame_shifter.sv
module uart_frame_shifter
  import uart_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [FRAME_MAX-1:0] frame,
  input  logic [LEN_W-1:0]     len,
  input  logic                 tick,
  output logic                 busy,
  output logic                 ready,
  output logic                 txd
);

  logic [FRAME_MAX-1:0] sh_q, sh_d;
  logic [LEN_W-1:0]     rem_q, rem_d;
  logic                 busy_q, busy_d;
  logic                 last_bit;

  assign last_bit = busy_q && tick && (rem_q == LEN_W'(1));
  assign ready    = !busy_q || last_bit;
  assign busy     = busy_q;
  assign txd      = busy_q ? sh_q[0] : 1'b1;

  always_comb begin
    sh_d   = sh_q;
    rem_d  = rem_q;
    busy_d = busy_q;
    if (load) begin
      sh_d   = frame;
      rem_d  = len;
      busy_d = 1'b1;
    end else if (busy_q && tick) begin
      sh_d  = {1'b1, sh_q[FRAME_MAX-1:1]};
      rem_d = rem_q - 1'b1;
      if (rem_q == LEN_W'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      rem_q  <= rem_d;
      busy_q <= busy_d;
    end
  end

endmodule

// File: rtl/uart_tx_arbiter.sv
module uart_tx_arbiter
  import uart_seq_pkg::*;
#(
  parameter int BRK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shf_ready_i,
  input  logic             stop_cmd_i,
  input  logic             restart_i,
  input  logic             oos_load_i,
  input  logic [7:0]       oos_data_i,
  input  logic             buf_valid_i,
  input  logic [7:0]       buf_data_i,
  input  logic [BRK_W-1:0] brk_count_i,
  output logic             load_o,
  output logic             load_brk_o,
  output logic [7:0]       load_data_o,
  output logic             buf_ready_o,
  output logic             oos_pending_o,
  output logic             stopped_o,
  output logic             done_o,
  output logic             in_break_o
);

  seq_state_t       state_q, state_d;
  logic             stop_q, stop_d, stop_now;
  logic             oosv_q, oosv_d;
  logic [7:0]       oos_q;
  logic [BRK_W-1:0] left_q, left_d;
  logic             done_q, done_d;

  always_comb begin
    state_d     = state_q;
    stop_d      = stop_q;
    oosv_d      = oosv_q;
    left_d      = left_q;
    done_d      = 1'b0;
    load_o      = 1'b0;
    load_brk_o  = 1'b0;
    load_data_o = buf_data_i;
    buf_ready_o = 1'b0;
    stop_now    = stop_q || stop_cmd_i;
    case (state_q)
      SQ_RUN: begin
        if (stop_cmd_i) stop_d = 1'b1;
        if (shf_ready_i) begin
          if (stop_now) begin
            stop_d = 1'b0;
            if (brk_count_i != '0) begin
              load_o     = 1'b1;
              load_brk_o = 1'b1;
              left_d     = brk_count_i - 1'b1;
              state_d    = SQ_BREAK;
            end else begin
              state_d = SQ_STOPPED;
              done_d  = 1'b1;
            end
          end else if (oosv_q) begin
            load_o      = 1'b1;
            load_data_o = oos_q;
            oosv_d      = 1'b0;
          end else begin
            buf_ready_o = 1'b1;
            load_o      = buf_valid_i;
          end
        end
      end
      SQ_BREAK: begin
        if (shf_ready_i) begin
          if (left_q != '0) begin
            load_o     = 1'b1;
            load_brk_o = 1'b1;
            left_d     = left_q - 1'b1;
          end else begin
            state_d = SQ_STOPPED;
            done_d  = 1'b1;
          end
        end
      end
      SQ_STOPPED: begin
        if (restart_i) state_d = SQ_RUN;
      end
      default: state_d = SQ_STOPPED;
    endcase
    if (oos_load_i) oosv_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_RUN;
      stop_q  <= 1'b0;
      oosv_q  <= 1'b0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stop_q  <= stop_d;
      oosv_q  <= oosv_d;
      left_q  <= left_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          oos_q <= '0;
    else if (oos_load_i) oos_q <= oos_data_i;
  end

  assign oos_pending_o = oosv_q;
  assign stopped_o     = (state_q == SQ_STOPPED);
  assign in_break_o    = (state_q == SQ_BREAK);
  assign done_o        = done_q;

endmodule

// File: rtl/uart_tx_brk_seq.sv
module uart_tx_brk_seq
  import uart_seq_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int BRK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] bit_div_i,
  input  logic [1:0]       data_sel_i,
  input  logic             parity_en_i,
  input  logic             parity_odd_i,
  input  logic             two_stop_i,
  input  logic [7:0]       buf_data_i,
  input  logic             buf_valid_i,
  output logic             buf_ready_o,
  input  logic [7:0]       oos_data_i,
  input  logic             oos_load_i,
  output logic             oos_pending_o,
  input  logic             stop_cmd_i,
  input  logic             restart_i,
  input  logic [BRK_W-1:0] brk_count_i,
  output logic             txd_o,
  output logic             stopped_o,
  output logic             brk_done_o
);

  frame_cfg_t           cfg;
  logic                 ld, ld_brk;
  logic [7:0]           ld_data;
  logic [FRAME_MAX-1:0] ld_frame;
  logic [LEN_W-1:0]     ld_len;
  logic                 shf_busy, shf_ready, bit_tick;
  logic                 seq_in_break;

  assign cfg      = {data_sel_i, parity_en_i, parity_odd_i, two_stop_i};
  assign ld_frame = ld_brk ? '0 : frame_bits(ld_data, cfg);
  assign ld_len   = frame_len(cfg);

  uart_tx_arbiter #(.BRK_W(BRK_W)) u_arb (
    .clk           (clk),
    .rst_n         (rst_n),
    .shf_ready_i   (shf_ready),
    .stop_cmd_i    (stop_cmd_i),
    .restart_i     (restart_i),
    .oos_load_i    (oos_load_i),
    .oos_data_i    (oos_data_i),
    .buf_valid_i   (buf_valid_i),
    .buf_data_i    (buf_data_i),
    .brk_count_i   (brk_count_i),
    .load_o        (ld),
    .load_brk_o    (ld_brk),
    .load_data_o   (ld_data),
    .buf_ready_o   (buf_ready_o),
    .oos_pending_o (oos_pending_o),
    .stopped_o     (stopped_o),
    .done_o        (brk_done_o),
    .in_break_o    (seq_in_break)
  );

  uart_bit_clock #(.DIV_W(DIV_W)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (shf_busy),
    .restart (ld),
    .div     (bit_div_i),
    .tick    (bit_tick)
  );

  uart_frame_shifter u_shf (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ld),
    .frame (ld_frame),
    .len   (ld_len),
    .tick  (bit_tick),
    .busy  (shf_busy),
    .ready (shf_ready),
    .txd   (txd_o)
  );

endmodule

// File: rtl/uart_tx_brk_seq_chk.sv
module uart_tx_brk_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic stopped,
  input logic done,
  input logic buf_ready,
  input logic oos_pending,
  input logic in_break
);

  AST_BREAK_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |-> !txd); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_STOPPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (stopped && txd)); // R9

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (!buf_ready && txd)); // R10

  AST_OOS_BLOCKS_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    oos_pending |-> !buf_ready); // R5

  AST_OOS_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oos_pending) |-> !txd); // R4

endmodule

bind uart_tx_brk_seq uart_tx_brk_seq_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .txd         (txd_o),
  .stopped     (stopped_o),
  .done        (brk_done_o),
  .buf_ready   (buf_ready_o),
  .oos_pending (oos_pending_o),
  .in_break    (seq_in_break)
);

// File: tb/test_uart_tx_brk_seq.sv
`timescale 1ns/1ps
module test_uart_tx_brk_seq;

  localparam int DIV = 3;
  localparam int BP  = DIV + 1;

  logic        clk;
  logic        rst_n;
  logic [15:0] bit_div;
  logic [1:0]  data_sel;
  logic        par_en, par_odd, two_stop;
  logic [7:0]  buf_data;
  logic        buf_valid, buf_ready;
  logic [7:0]  oos_data;
  logic        oos_load, oos_pending;
  logic        stop_cmd, restart;
  logic [15:0] brk_count;
  logic        txd, stopped, brk_done;

  int checks = 0;
  int errors = 0;
  int done_seen = 0;
  int low_clocks = 0;

  logic [7:0] feed_mem [0:31];
  int fed = 0;
  int nfeed = 0;

  assign buf_valid = (fed < nfeed);
  assign buf_data  = feed_mem[fed[4:0]];

  uart_tx_brk_seq i_uart_tx_brk_seq (
    .clk(clk), .rst_n(rst_n), .bit_div_i(bit_div), .data_sel_i(data_sel),
    .parity_en_i(par_en), .parity_odd_i(par_odd), .two_stop_i(two_stop),
    .buf_data_i(buf_data), .buf_valid_i(buf_valid), .buf_ready_o(buf_ready),
    .oos_data_i(oos_data), .oos_load_i(oos_load), .oos_pending_o(oos_pending),
    .stop_cmd_i(stop_cmd), .restart_i(restart), .brk_count_i(brk_count),
    .txd_o(txd), .stopped_o(stopped), .brk_done_o(brk_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) if (buf_valid && buf_ready) fed <= fed + 1;
  always @(negedge clk) begin
    if (brk_done) done_seen++;
    if (!txd) low_clocks++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int flen(int ds, int pe, int ts);
    return 7 + ds + pe + ts;
  endfunction

  function automatic int exp_frame(int d, int ds, int pe, int po, int ts);
    int nd, v, p, r;
    nd = 5 + ds;
    v  = d & ((1 << nd) - 1);
    p  = po;
    for (int i = 0; i < nd; i++) p = p ^ ((v >> i) & 1);
    r = v << 1;
    if (pe != 0) r = r | (p << (1 + nd));
    for (int k = 1 + nd + pe; k < 12; k++) r = r | (1 << k);
    return r;
  endfunction

  task automatic set_cfg(input int ds, input int pe, input int po, input int ts);
    data_sel = ds[1:0]; par_en = pe[0]; par_odd = po[0]; two_stop = ts[0];
  endtask

  task automatic push(input logic [7:0] b);
    feed_mem[nfeed[4:0]] = b;
    nfeed++;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_cmd = 1'b1;
    @(negedge clk) stop_cmd = 1'b0;
  endtask

  task automatic pulse_restart();
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
  endtask

  task automatic pulse_oos(input logic [7:0] b);
    @(negedge clk) begin oos_data = b; oos_load = 1'b1; end
    @(negedge clk) oos_load = 1'b0;
  endtask

  // Decode one frame of n bits, sampling near each bit centre
  task automatic rx_frame(input int n, output int bits);
    int t = 0;
    bits = 0;
    while (txd && t < 3000) begin @(negedge clk); t++; end
    if (txd) begin bits = -1; return; end
    @(negedge clk);
    bits = int'(txd);
    for (int k = 1; k < n; k++) begin
      repeat (BP) @(negedge clk);
      bits = bits | (int'(txd) << k);
    end
  endtask

  task automatic low_run(output int len);
    int t = 0;
    while (txd && t < 500) begin @(negedge clk); t++; end
    len = 0;
    while (!txd && len < 20000) begin len++; @(negedge clk); end
  endtask

  task automatic expect_char(input int d, input int ds, input int pe, input int po,
                             input int ts, input string req);
    int got, ex, m;
    m  = (1 << flen(ds, pe, ts)) - 1;
    ex = exp_frame(d, ds, pe, po, ts) & m;
    rx_frame(flen(ds, pe, ts), got);
    chk((got & m) == ex, req, got & m, ex);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int len, d0, lc0, fed0;
    rst_n = 1'b0; bit_div = 16'(DIV); set_cfg(3, 0, 0, 0);
    oos_data = 8'h00; oos_load = 1'b0; stop_cmd = 1'b0; restart = 1'b0;
    brk_count = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(txd == 1'b1, "R1 line", int'(txd), 1);
    chk(stopped == 1'b0 && brk_done == 1'b0, "R1 stopped/done", int'({stopped, brk_done}), 0);
    chk(oos_pending == 1'b0 && buf_ready == 1'b1, "R1 pending/ready",
        int'({oos_pending, buf_ready}), 1);

    // R2 sweep over every frame format
    for (int ds = 0; ds < 4; ds++)
      for (int pm = 0; pm < 3; pm++)
        for (int ts = 0; ts < 2; ts++) begin
          int d;
          d = (8'h5A + (ds * 6 + pm * 2 + ts) * 29) & 8'hFF;
          set_cfg(ds, (pm != 0) ? 1 : 0, (pm == 2) ? 1 : 0, ts);
          @(negedge clk);
          push(d[7:0]);
          expect_char(d, ds, (pm != 0) ? 1 : 0, (pm == 2) ? 1 : 0, ts, "R2 frame");
          repeat (BP * 3) @(negedge clk);
        end

    // R3 back-to-back stream order
    set_cfg(3, 0, 0, 0);
    @(negedge clk);
    push(8'h31); push(8'hC2); push(8'h07); push(8'hFE);
    expect_char(8'h31, 3, 0, 0, 0, "R3 byte0");
    expect_char(8'hC2, 3, 0, 0, 0, "R3 byte1");
    expect_char(8'h07, 3, 0, 0, 0, "R3 byte2");
    expect_char(8'hFE, 3, 0, 0, 0, "R3 byte3");
    repeat (BP * 3) @(negedge clk);

    // R4/R5 insertion while the first buffer byte is mid-frame
    set_cfg(3, 1, 0, 0);
    @(negedge clk);
    push(8'hA1); push(8'hB2); push(8'hC3);
    fork
      begin
        repeat (10) @(negedge clk);
        pulse_oos(8'h13);
        chk(oos_pending == 1'b1 && buf_ready == 1'b0, "R5 pending blocks buffer",
            int'({oos_pending, buf_ready}), 2);
      end
    join_none
    expect_char(8'hA1, 3, 1, 0, 0, "R5 byte in progress intact");
    expect_char(8'h13, 3, 1, 0, 0, "R4 inserted next");
    chk(oos_pending == 1'b0, "R4 pending cleared", int'(oos_pending), 0);
    expect_char(8'hB2, 3, 1, 0, 0, "R4 buffer order 1");
    expect_char(8'hC3, 3, 1, 0, 0, "R4 buffer order 2");
    repeat (BP * 3) @(negedge clk);

    // R7/R9 break run sweep
    for (int c = 0; c < 4; c++)
      for (int n = 1; n <= 3; n++) begin
        int ds, pe, ts;
        ds = (c == 1) ? 0 : ((c == 3) ? 2 : 3);
        pe = (c >= 2) ? 1 : 0;
        ts = (c == 2) ? 1 : 0;
        set_cfg(ds, pe, c & 1, ts);
        brk_count = 16'(n);
        d0 = done_seen;
        pulse_stop();
        low_run(len);
        chk(len == n * flen(ds, pe, ts) * BP, "R7 break length", len, n * flen(ds, pe, ts) * BP);
        @(negedge clk);
        chk(done_seen == d0 + 1 && stopped && txd, "R9 done once, idle stopped",
            done_seen - d0, 1);
        pulse_restart();
        @(negedge clk);
      end

    // R8 zero count
    set_cfg(3, 0, 0, 0);
    brk_count = 16'd0;
    d0 = done_seen; lc0 = low_clocks;
    pulse_stop();
    repeat (20) @(negedge clk);
    chk(low_clocks == lc0, "R8 no break sent", low_clocks - lc0, 0);
    chk(stopped == 1'b1 && done_seen == d0 + 1, "R8 stopped with done", done_seen - d0, 1);
    pulse_restart();
    @(negedge clk);

    // R6 stop during a character, another byte waiting
    brk_count = 16'd2;
    push(8'h6D); push(8'h92);
    fork
      begin
        repeat (12) @(negedge clk);
        pulse_stop();
      end
    join_none
    expect_char(8'h6D, 3, 0, 0, 0, "R6 current char completes");
    low_run(len);
    chk(len == 2 * 10 * BP, "R6 break follows char", len, 2 * 10 * BP);
    chk(buf_valid == 1'b1 && stopped == 1'b1, "R6 waiting byte not taken",
        int'({buf_valid, stopped}), 3);

    // R10 stopped holds; restart resumes with insertion first
    fed0 = fed; lc0 = low_clocks;
    pulse_oos(8'h11);
    repeat (200) @(negedge clk);
    chk(fed == fed0 && low_clocks == lc0 && txd, "R10 stopped quiet", low_clocks - lc0, 0);
    chk(oos_pending == 1'b1, "R10 insertion held", int'(oos_pending), 1);
    pulse_restart();
    expect_char(8'h11, 3, 0, 0, 0, "R10 insertion after restart");
    expect_char(8'h92, 3, 0, 0, 0, "R10 buffer resumes");
    repeat (BP * 3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule